// File: doc/BRIEF.md
# Dual-Lane 64-bit Integer ALU

This unit runs one integer operation on two independent 64-bit lanes at once. Each source is a 128-bit vector of four 32-bit components named x, y, z and w. Lane 0 is built from x (low word) and y (high word). Lane 1 is built from z (low word) and w (high word). A 4-bit opcode picks a compare, a minimum or maximum, or a shift. The result is held in a register and appears one cycle after an accepted input.

Compares produce a 32-bit mask: all ones when the condition is true and zero when it is false. Lane 0's mask goes to slot x and lane 1's mask goes to slot z; slots y and w are zero. Minimum and maximum write the whole 64-bit winner into the lane's two slots. Shifts take the first source as the value. The count for lane 0 comes from component x of the second source and the count for lane 1 from component y of the second source. Only the count's low six bits are used.

Top module: `dual_lane_alu64`

## Requirements
- R1: The opcode encoding is EQ=0, NE=1, ULT=2, UGE=3, SLT=4, SGE=5, UMIN=6, UMAX=7, SMIN=8, SMAX=9, SHL=10, SRA=11, SRL=12. Any other value yields an all-zero result.
- R2: In both source and result, component x is bits [31:0], y is [63:32], z is [95:64] and w is [127:96]. Lane 0 is {y,x} and lane 1 is {w,z}.
- R3: EQ and NE compare all 64 bits of each lane and ignore signedness.
- R4: ULT and UGE compare the lanes as unsigned numbers. SLT and SGE compare them as two's-complement numbers.
- R5: A compare writes 32'hFFFFFFFF when true and 0 when false. Lane 0's result goes to x, lane 1's to z, and y and w are zero.
- R6: UMIN, UMAX, SMIN and SMAX write the selected 64-bit operand, in the stated signedness, to {y,x} for lane 0 and to {w,z} for lane 1.
- R7: Before shifting, the count is masked to six bits (AND 0x3f). Lane 0 uses src1 bits [5:0] and lane 1 uses src1 bits [37:32]. The upper bits of the count have no effect.
- R8: SHL fills with zeros from the right. SRA copies bit 63 into the vacated bits. SRL fills with zeros from the left.
- R9: The result register loads only in a cycle with inValid high. If inValid is low, the result holds its value.
- R10: outValid equals inValid delayed by one cycle. Reset clears outValid and the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Inputs are valid this cycle |
| opSel | input | 4 | Operation code |
| srcA | input | 128 | First source vector |
| srcB | input | 128 | Second source vector / shift counts |
| outValid | output | 1 | Result is valid |
| result | output | 128 | Destination vector |

## Verification
The bench targets operands that differ only in the high word or only in the sign bit. A design that compares just the low word, or that uses the wrong signedness, gives a different answer on these cases. Shift counts of 0, 63 and values with bits above bit 5 set are tested. A design that does not mask the count returns zero or a wrongly shifted value. A design that swaps the count sources puts lane 1's shift into lane 0. Negative values are shifted right arithmetically and logically, which exposes a swapped fill. Cycles with inValid low follow a valid result, so a register that updates anyway shows up as a changed result.

// File: rtl/alu64_pkg.sv
package alu64_pkg;
  localparam int LaneW = 64;
  localparam int CompW = 32;
  localparam int Lanes = 2;
  localparam int VecW  = LaneW * Lanes;
  localparam int CntW  = 6;

  typedef enum logic [3:0] {
    OP_EQ = 4'd0, OP_NE = 4'd1, OP_ULT = 4'd2, OP_UGE = 4'd3,
    OP_SLT = 4'd4, OP_SGE = 4'd5, OP_UMIN = 4'd6, OP_UMAX = 4'd7,
    OP_SMIN = 4'd8, OP_SMAX = 4'd9, OP_SHL = 4'd10, OP_SRA = 4'd11,
    OP_SRL = 4'd12
  } opcode_e;

  typedef enum logic [2:0] {
    CMP_EQ, CMP_NE, CMP_LT, CMP_GE
  } cmp_kind_e;

  typedef struct packed {
    logic      load;
    logic      isCmp;
    logic      isMinMax;
    logic      isShift;
    logic      signedOp;
    cmp_kind_e cmpKind;
    logic      pickMax;
    logic [1:0] shiftKind; // 0 left, 1 arith right, 2 logical right
  } ctrl_t;
endpackage

// File: rtl/alu64_ctrl.sv
module alu64_ctrl
  import alu64_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [3:0] opSel,
  output ctrl_t      ctrl,
  output logic       outValid
);
  always_comb begin
    ctrl = '0;
    ctrl.load = inValid;
    ctrl.cmpKind = CMP_EQ;
    unique case (opSel)
      OP_EQ:   begin ctrl.isCmp = 1'b1; ctrl.cmpKind = CMP_EQ; end
      OP_NE:   begin ctrl.isCmp = 1'b1; ctrl.cmpKind = CMP_NE; end
      OP_ULT:  begin ctrl.isCmp = 1'b1; ctrl.cmpKind = CMP_LT; end
      OP_UGE:  begin ctrl.isCmp = 1'b1; ctrl.cmpKind = CMP_GE; end
      OP_SLT:  begin ctrl.isCmp = 1'b1; ctrl.cmpKind = CMP_LT; ctrl.signedOp = 1'b1; end
      OP_SGE:  begin ctrl.isCmp = 1'b1; ctrl.cmpKind = CMP_GE; ctrl.signedOp = 1'b1; end
      OP_UMIN: begin ctrl.isMinMax = 1'b1; end
      OP_UMAX: begin ctrl.isMinMax = 1'b1; ctrl.pickMax = 1'b1; end
      OP_SMIN: begin ctrl.isMinMax = 1'b1; ctrl.signedOp = 1'b1; end
      OP_SMAX: begin ctrl.isMinMax = 1'b1; ctrl.pickMax = 1'b1; ctrl.signedOp = 1'b1; end
      OP_SHL:  begin ctrl.isShift = 1'b1; ctrl.shiftKind = 2'd0; end
      OP_SRA:  begin ctrl.isShift = 1'b1; ctrl.shiftKind = 2'd1; end
      OP_SRL:  begin ctrl.isShift = 1'b1; ctrl.shiftKind = 2'd2; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  assert_valid_delay_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (outValid == $past(inValid)));
  assert_one_class_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.isCmp, ctrl.isMinMax, ctrl.isShift}));
endmodule

// File: rtl/alu64_datapath.sv
module alu64_datapath
  import alu64_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  ctrl_t           ctrl,
  input  logic [VecW-1:0] srcA,
  input  logic [VecW-1:0] srcB,
  output logic [VecW-1:0] result
);
  logic [VecW-1:0] nextRes;

  for (genvar g = 0; g < Lanes; g++) begin : gLane
    logic [LaneW-1:0] a, b, lo, hi, shOut;
    logic [CntW-1:0]  cnt;
    logic eq, lt, cmpTrue;
    assign a   = srcA[g*LaneW +: LaneW];
    assign b   = srcB[g*LaneW +: LaneW];
    assign cnt = srcB[g*CompW +: CntW];
    assign eq  = (a == b);
    assign lt  = ctrl.signedOp ? ($signed(a) < $signed(b)) : (a < b);
    assign lo  = lt ? a : b;
    assign hi  = lt ? b : a;
    always_comb begin
      unique case (ctrl.cmpKind)
        CMP_EQ:  cmpTrue = eq;
        CMP_NE:  cmpTrue = !eq;
        CMP_LT:  cmpTrue = lt;
        default: cmpTrue = !lt;
      endcase
      unique case (ctrl.shiftKind)
        2'd0:    shOut = a << cnt;
        2'd1:    shOut = LaneW'($signed(a) >>> cnt);
        default: shOut = a >> cnt;
      endcase
    end
    always_comb begin
      if (ctrl.isCmp)
        nextRes[g*LaneW +: LaneW] = {{CompW{1'b0}}, {CompW{cmpTrue}}};
      else if (ctrl.isMinMax)
        nextRes[g*LaneW +: LaneW] = ctrl.pickMax ? hi : lo;
      else if (ctrl.isShift)
        nextRes[g*LaneW +: LaneW] = shOut;
      else
        nextRes[g*LaneW +: LaneW] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          result <= '0;
    else if (ctrl.load) result <= nextRes;
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(ctrl.load)) |-> $stable(result));
  assert_cmp_mask_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(ctrl.load) && $past(ctrl.isCmp)) |->
      (result[63:32] == '0 && result[127:96] == '0 &&
       (result[31:0] == '0 || result[31:0] == '1) &&
       (result[95:64] == '0 || result[95:64] == '1)));
endmodule

// File: rtl/dual_lane_alu64.sv
module dual_lane_alu64
  import alu64_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [3:0]   opSel,
  input  logic [127:0] srcA,
  input  logic [127:0] srcB,
  output logic         outValid,
  output logic [127:0] result
);
  ctrl_t ctrl;

  alu64_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .ctrl(ctrl), .outValid(outValid)
  );

  alu64_datapath uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .srcA(srcA), .srcB(srcB),
    .result(result)
  );
endmodule

// File: tb/dual_lane_alu64_test.sv
module dual_lane_alu64_test;
  logic clk = 0, rstN = 0, inValid = 0;
  logic [3:0] opSel = 0;
  logic [127:0] srcA = 0, srcB = 0;
  logic outValid;
  logic [127:0] result;
  int checks = 0, errors = 0;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  always #5 clk = ~clk;

  dual_lane_alu64 uut (.clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .srcA(srcA), .srcB(srcB), .outValid(outValid), .result(result));

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive one op, sample after the registering edge
  task automatic runOp(input logic [3:0] op, input logic [63:0] a0, a1, b0, b1,
                       input logic [127:0] exp, input string req);
    @(negedge clk);
    opSel = op; srcA = {a1, a0}; srcB = {b1, b0}; inValid = 1;
    @(negedge clk);
    inValid = 0;
    check(req, result, exp);
    check({req, " R10 valid"}, {127'd0, outValid}, 128'd1);
  endtask

  function automatic logic [127:0] cmpRes(input logic c0, c1);
    return {32'd0, c1 ? ONES : 32'd0, 32'd0, c0 ? ONES : 32'd0};
  endfunction

  task automatic testReset;
    check("R10 reset result", result, 128'd0);
    check("R10 reset valid", {127'd0, outValid}, 128'd0);
  endtask

  task automatic testEquality;
    // R3: differ only in high word on lane 0
    runOp(4'd0, 64'h1_0000_0005, 64'h7, 64'h2_0000_0005, 64'h7, cmpRes(0, 1), "R3 EQ");
    runOp(4'd1, 64'h1_0000_0005, 64'h7, 64'h2_0000_0005, 64'h7, cmpRes(1, 0), "R3 NE");
  endtask

  task automatic testOrder;
    logic [63:0] neg = 64'hFFFF_FFFF_FFFF_FFFE; // -2
    runOp(4'd2, neg, 64'd3, 64'd1, 64'd3, cmpRes(0, 0), "R4 ULT");
    runOp(4'd3, neg, 64'd3, 64'd1, 64'd4, cmpRes(1, 0), "R4 UGE");
    runOp(4'd4, neg, 64'd3, 64'd1, 64'd3, cmpRes(1, 0), "R4 SLT");
    runOp(4'd5, neg, 64'd3, 64'd1, 64'd3, cmpRes(0, 1), "R4 R5 SGE");
  endtask

  task automatic testMinMax;
    logic [63:0] neg = 64'h8000_0000_0000_0001;
    logic [63:0] pos = 64'h0000_0001_0000_0000;
    runOp(4'd6, neg, pos, pos, 64'd9, {64'd9, pos}, "R6 UMIN");
    runOp(4'd7, neg, pos, pos, 64'd9, {pos, neg}, "R6 UMAX");
    runOp(4'd8, neg, pos, pos, 64'd9, {64'd9, neg}, "R6 SMIN");
    runOp(4'd9, neg, pos, pos, 64'd9, {pos, pos}, "R6 SMAX");
  endtask

  task automatic testShift;
    logic [63:0] v = 64'h8000_0000_0000_00F0;
    // R7: lane0 count from srcB[31:0]=0x44 -> 4; lane1 from srcB[63:32]=0x7F -> 63
    runOp(4'd10, v, v, {32'h0000_007F, 32'h0000_0044}, 64'hDEAD,
          {64'd0, 64'h0000_0000_0000_0F00}, "R7 R8 SHL");
    runOp(4'd11, v, v, {32'd63, 32'd4}, 64'd0,
          {64'hFFFF_FFFF_FFFF_FFFF, 64'hF800_0000_0000_000F}, "R8 SRA");
    runOp(4'd12, v, v, {32'd63, 32'd4}, 64'd0,
          {64'd1, 64'h0800_0000_0000_000F}, "R8 SRL");
    runOp(4'd12, v, v, {32'd0, 32'd64}, 64'd0, {v, v}, "R7 count zero");
  endtask

  task automatic testHoldAndIllegal;
    runOp(4'd15, 64'd5, 64'd5, 64'd5, 64'd5, 128'd0, "R1 unused opcode");
    runOp(4'd7, 64'd5, 64'd6, 64'd2, 64'd9, {64'd9, 64'd5}, "R2 lane layout");
    @(negedge clk);
    opSel = 4'd0; srcA = '1; srcB = '1; inValid = 0;
    @(negedge clk);
    check("R9 hold", result, {64'd9, 64'd5});
    check("R10 valid low", {127'd0, outValid}, 128'd0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        testReset();
        rstN = 1;
        testEquality();
        testOrder();
        testMinMax();
        testShift();
        testHoldAndIllegal();
      end
      begin
        repeat (10000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired act=timeout exp=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule